// File: doc/BRIEF.md
# USB Device Command Register Interface

This block is the configuration front end of a USB device controller. A local controller talks to it over a byte-wide port with two strobes. A command strobe presents an opcode byte and opens a transaction. Each later data strobe presents one argument byte. The block decodes three opcodes: device address, endpoint enable, and a mode opcode that takes several bytes. It keeps the resulting settings in registers and drives them continuously to the rest of the device.

The mode opcode accepts a run of one to four argument bytes. The position of each byte selects the field it writes: mode flags, the low part of a 10-bit isochronous packet size, the high part of that size, and a FIFO offset. A short run writes only the leading fields. The other fields keep their values. Bytes beyond what an opcode accepts are dropped, and so are bytes that follow an opcode the block does not recognise.

Top module: `usb_cfg_regs`

## Requirements
- R1: A synchronous active-high `rst` sets addr_valid=0, dev_addr=0, ep_enable=0, fifo_active=1, clk_keepalive=1, nak_irq_en=1, iso_pkt_size=0 and fifo_offset=0. After reset no opcode is open, so a data byte changes nothing until a command strobe arrives.
- R2: After opcode 0xD0, the first argument byte sets addr_valid from bit 7 and dev_addr from bits 6:0.
- R3: After opcode 0xD8, the first argument byte sets ep_enable from bit 0. Bits 7:1 are ignored.
- R4: After opcode 0xF3, argument byte 0 sets fifo_active from bit 2, clk_keepalive from bit 1 and nak_irq_en from bit 0. Bits 7:3 are ignored.
- R5: After opcode 0xF3, argument byte 1 sets iso_pkt_size[7:0]. Bits 1:0 of argument byte 2 set iso_pkt_size[9:8], and bits 7:2 of that byte are ignored.
- R6: After opcode 0xF3, argument byte 3 sets fifo_offset.
- R7: When an 0xF3 transfer is shorter than four bytes, every field at a byte position it did not reach keeps its previous value.
- R8: Argument bytes beyond the first for 0xD0 and 0xD8, and beyond the fourth for 0xF3, change no output.
- R9: Argument bytes that follow any opcode other than 0xD0, 0xD8 or 0xF3 change no output.
- R10: A command strobe sets the argument index back to 0 and changes no output by itself. When both strobes are high in the same cycle, the byte is taken as an opcode and no argument is written.
- R11: A written field shows its new value at the first rising clock edge at which its data strobe is sampled high, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_stb | input | 1 | Present `wr_byte` as an opcode |
| data_stb | input | 1 | Present `wr_byte` as the next argument byte |
| wr_byte | input | 8 | Opcode or argument byte |
| addr_valid | output | 1 | Device address is enabled |
| dev_addr | output | 7 | USB-assigned device address |
| ep_enable | output | 1 | Non-control endpoints enabled |
| fifo_active | output | 1 | Video FIFO in normal operation; when 0 only zero-length packets go upstream |
| clk_keepalive | output | 1 | Clocks and PLL keep running during suspend |
| nak_irq_en | output | 1 | NAK handshakes are reported and raise an interrupt |
| iso_pkt_size | output | 10 | Isochronous packet size |
| fifo_offset | output | 8 | FIFO offset |

## Verification
A vector table runs one opcode per row through the block and carries the register state from row to row. The rows cover full and short mode transfers, over-long transfers and unknown opcodes. Because the state carries over, a byte written to the wrong position or a field cleared by mistake shows up as a mismatch in a later row. The reserved bits are set to 1 in the argument bytes, so a mask that is too wide is caught. The directed tests come after the table. They restart a transfer in the middle, assert both strobes in the same cycle, send a fifth mode byte, send data with no opcode open after reset, and sample on both sides of the update edge.

// File: rtl/usb_cfg_pkg.sv
package usb_cfg_pkg;

    parameter int BYTE_W    = 8;
    parameter int ADDR_W    = 7;
    parameter int PKT_W     = 10;
    parameter int OFF_W     = 8;
    parameter int MODE_MAX  = 4;
    localparam int IDX_W    = $clog2(MODE_MAX + 1);
    localparam int PKT_HI_W = PKT_W - BYTE_W;

    parameter logic [BYTE_W-1:0] OP_ADDR = 8'hD0;
    parameter logic [BYTE_W-1:0] OP_EPEN = 8'hD8;
    parameter logic [BYTE_W-1:0] OP_MODE = 8'hF3;

    localparam int FLAG_FIFO = 2;
    localparam int FLAG_KEEP = 1;
    localparam int FLAG_NAK  = 0;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ADDR = 2'd1,
        CMD_EPEN = 2'd2,
        CMD_MODE = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        logic              addr_valid;
        logic [ADDR_W-1:0] dev_addr;
        logic              ep_enable;
        logic              fifo_active;
        logic              clk_keepalive;
        logic              nak_irq_en;
        logic [PKT_W-1:0]  iso_pkt_size;
        logic [OFF_W-1:0]  fifo_offset;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        addr_valid:    1'b0,
        dev_addr:      '0,
        ep_enable:     1'b0,
        fifo_active:   1'b1,
        clk_keepalive: 1'b1,
        nak_irq_en:    1'b1,
        iso_pkt_size:  '0,
        fifo_offset:   '0
    };

    function automatic cmd_kind_e decode_op(input logic [BYTE_W-1:0] op);
        if (op == OP_ADDR)      return CMD_ADDR;
        else if (op == OP_EPEN) return CMD_EPEN;
        else if (op == OP_MODE) return CMD_MODE;
        else                    return CMD_NONE;
    endfunction

    function automatic logic [IDX_W-1:0] byte_limit(input cmd_kind_e k);
        case (k)
            CMD_ADDR: return IDX_W'(1);
            CMD_EPEN: return IDX_W'(1);
            CMD_MODE: return IDX_W'(MODE_MAX);
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/usb_cfg_cmd_track.sv
module usb_cfg_cmd_track
    import usb_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_stb,
    input  logic              data_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    output cmd_kind_e         cmd_kind,
    output logic [IDX_W-1:0]  byte_idx,
    output logic              arg_we
);

    typedef struct packed {
        cmd_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d  = trk_q;
        arg_we = 1'b0;
        if (cmd_stb) begin
            trk_d.kind = decode_op(wr_byte);
            trk_d.idx  = '0;
        end else if (data_stb) begin
            arg_we = (trk_q.idx < byte_limit(trk_q.kind));
            if (trk_q.idx != IDX_W'(MODE_MAX)) begin
                trk_d.idx = trk_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '{kind: CMD_NONE, idx: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign cmd_kind = trk_q.kind;
    assign byte_idx = trk_q.idx;

endmodule

// File: rtl/usb_cfg_field_wr.sv
module usb_cfg_field_wr
    import usb_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arg_we,
    input  cmd_kind_e         cmd_kind,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [BYTE_W-1:0] wr_byte,
    output cfg_t              cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (arg_we) begin
            unique case (cmd_kind)
                CMD_ADDR: begin
                    cfg_d.addr_valid = wr_byte[BYTE_W-1];
                    cfg_d.dev_addr   = wr_byte[ADDR_W-1:0];
                end
                CMD_EPEN: begin
                    cfg_d.ep_enable = wr_byte[0];
                end
                CMD_MODE: begin
                    case (byte_idx)
                        IDX_W'(0): begin
                            cfg_d.fifo_active   = wr_byte[FLAG_FIFO];
                            cfg_d.clk_keepalive = wr_byte[FLAG_KEEP];
                            cfg_d.nak_irq_en    = wr_byte[FLAG_NAK];
                        end
                        IDX_W'(1): cfg_d.iso_pkt_size[BYTE_W-1:0] = wr_byte;
                        IDX_W'(2): cfg_d.iso_pkt_size[PKT_W-1:BYTE_W] =
                                       wr_byte[PKT_HI_W-1:0];
                        IDX_W'(3): cfg_d.fifo_offset = wr_byte[OFF_W-1:0];
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/usb_cfg_regs.sv
module usb_cfg_regs
    import usb_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_stb,
    input  logic        data_stb,
    input  logic [7:0]  wr_byte,
    output logic        addr_valid,
    output logic [6:0]  dev_addr,
    output logic        ep_enable,
    output logic        fifo_active,
    output logic        clk_keepalive,
    output logic        nak_irq_en,
    output logic [9:0]  iso_pkt_size,
    output logic [7:0]  fifo_offset
);

    cmd_kind_e        cmd_kind;
    logic [IDX_W-1:0] byte_idx;
    logic             arg_we;
    cfg_t             cfg;

    usb_cfg_cmd_track u_track (
        .clk      (clk),
        .rst      (rst),
        .cmd_stb  (cmd_stb),
        .data_stb (data_stb),
        .wr_byte  (wr_byte),
        .cmd_kind (cmd_kind),
        .byte_idx (byte_idx),
        .arg_we   (arg_we)
    );

    usb_cfg_field_wr u_fields (
        .clk      (clk),
        .rst      (rst),
        .arg_we   (arg_we),
        .cmd_kind (cmd_kind),
        .byte_idx (byte_idx),
        .wr_byte  (wr_byte),
        .cfg      (cfg)
    );

    assign addr_valid    = cfg.addr_valid;
    assign dev_addr      = cfg.dev_addr;
    assign ep_enable     = cfg.ep_enable;
    assign fifo_active   = cfg.fifo_active;
    assign clk_keepalive = cfg.clk_keepalive;
    assign nak_irq_en    = cfg.nak_irq_en;
    assign iso_pkt_size  = cfg.iso_pkt_size;
    assign fifo_offset   = cfg.fifo_offset;

endmodule

// File: rtl/usb_cfg_regs_chk.sv
module usb_cfg_regs_chk
    import usb_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_stb,
    input logic             data_stb,
    input logic [7:0]       wr_byte,
    input logic             addr_valid,
    input logic [6:0]       dev_addr,
    input logic             ep_enable,
    input logic             fifo_active,
    input logic             clk_keepalive,
    input logic             nak_irq_en,
    input logic [9:0]       iso_pkt_size,
    input logic [7:0]       fifo_offset,
    input cmd_kind_e        cmd_kind,
    input logic [IDX_W-1:0] byte_idx
);

    logic [29:0] outs;
    assign outs = {addr_valid, dev_addr, ep_enable, fifo_active, clk_keepalive,
                   nak_irq_en, iso_pkt_size, fifo_offset};

    logic take;
    assign take = data_stb && !cmd_stb;

    assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (outs == {1'b0, 7'h00, 1'b0, 3'b111, 10'h000, 8'h00}));

    assert_addr_write_R2: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_kind == CMD_ADDR && byte_idx == 0) |=>
        (addr_valid == $past(wr_byte[7]) && dev_addr == $past(wr_byte[6:0])));

    assert_ep_write_R3: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_kind == CMD_EPEN && byte_idx == 0) |=>
        (ep_enable == $past(wr_byte[0])));

    assert_mode_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_kind == CMD_MODE && byte_idx == 0) |=>
        ({fifo_active, clk_keepalive, nak_irq_en} == $past(wr_byte[2:0])));

    assert_pkt_high_R5: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_kind == CMD_MODE && byte_idx == 2) |=>
        (iso_pkt_size[9:8] == $past(wr_byte[1:0]) && $stable(iso_pkt_size[7:0])));

    assert_offset_write_R6: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_kind == CMD_MODE && byte_idx == 3) |=>
        (fifo_offset == $past(wr_byte)));

    assert_excess_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (take && byte_idx >= IDX_W'(MODE_MAX)) |=> $stable(outs));

    assert_unknown_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        (data_stb && cmd_kind == CMD_NONE) |=> $stable(outs));

    assert_cmd_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |=> ($stable(outs) && byte_idx == 0));

endmodule

bind usb_cfg_regs usb_cfg_regs_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_stb       (cmd_stb),
    .data_stb      (data_stb),
    .wr_byte       (wr_byte),
    .addr_valid    (addr_valid),
    .dev_addr      (dev_addr),
    .ep_enable     (ep_enable),
    .fifo_active   (fifo_active),
    .clk_keepalive (clk_keepalive),
    .nak_irq_en    (nak_irq_en),
    .iso_pkt_size  (iso_pkt_size),
    .fifo_offset   (fifo_offset),
    .cmd_kind      (cmd_kind),
    .byte_idx      (byte_idx)
);

// File: tb/test_usb_cfg_regs.sv
module test_usb_cfg_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_stb = 1'b0;
    logic       data_stb = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       addr_valid, ep_enable, fifo_active, clk_keepalive, nak_irq_en;
    logic [6:0] dev_addr;
    logic [9:0] iso_pkt_size;
    logic [7:0] fifo_offset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    usb_cfg_regs i_usb_cfg_regs (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .data_stb(data_stb),
        .wr_byte(wr_byte), .addr_valid(addr_valid), .dev_addr(dev_addr),
        .ep_enable(ep_enable), .fifo_active(fifo_active),
        .clk_keepalive(clk_keepalive), .nak_irq_en(nak_irq_en),
        .iso_pkt_size(iso_pkt_size), .fifo_offset(fifo_offset)
    );

    // Observed vector: {addr_valid, dev_addr, ep_enable, fifo_active,
    //                   clk_keepalive, nak_irq_en, iso_pkt_size, fifo_offset}
    logic [29:0] obs;
    assign obs = {addr_valid, dev_addr, ep_enable, fifo_active, clk_keepalive,
                  nak_irq_en, iso_pkt_size, fifo_offset};

    localparam logic [29:0] DEFAULTS = {1'b0, 7'h00, 1'b0, 3'b111, 10'h000, 8'h00};

    // Row: {opcode[8], byte count[3], bytes {b3,b2,b1,b0}[32], expected[30]}
    localparam int NV = 8;
    localparam logic [72:0] VEC [NV] = '{
        {8'hD0, 3'd1, 32'h0000_0085, {1'b1, 7'h05, 1'b0, 3'b111, 10'h000, 8'h00}},
        {8'hD8, 3'd1, 32'h0000_00FF, {1'b1, 7'h05, 1'b1, 3'b111, 10'h000, 8'h00}},
        {8'hF3, 3'd4, 32'h9CFE_34F8, {1'b1, 7'h05, 1'b1, 3'b000, 10'h234, 8'h9C}},
        {8'hF3, 3'd2, 32'h0000_1105, {1'b1, 7'h05, 1'b1, 3'b101, 10'h211, 8'h9C}},
        {8'hD0, 3'd3, 32'h00FF_FF2A, {1'b0, 7'h2A, 1'b1, 3'b101, 10'h211, 8'h9C}},
        {8'h55, 3'd2, 32'h0000_FFFF, {1'b0, 7'h2A, 1'b1, 3'b101, 10'h211, 8'h9C}},
        {8'hD8, 3'd2, 32'h0000_0102, {1'b0, 7'h2A, 1'b0, 3'b101, 10'h211, 8'h9C}},
        {8'hF3, 3'd3, 32'h0001_0007, {1'b0, 7'h2A, 1'b0, 3'b111, 10'h100, 8'h9C}}
    };
    localparam string VTAG [NV] = '{"R2", "R3", "R4 R5 R6", "R7", "R8",
                                    "R9", "R3 R8", "R5 R7"};

    task automatic check(input string req, input logic [29:0] act,
                         input logic [29:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Tasks are entered at a falling edge and return at the next one.
    task automatic send_cmd(input logic [7:0] op);
        cmd_stb = 1'b1; wr_byte = op;
        @(negedge clk);
        cmd_stb = 1'b0;
    endtask

    task automatic send_data(input logic [7:0] b);
        data_stb = 1'b1; wr_byte = b;
        @(negedge clk);
        data_stb = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [29:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset values", obs, DEFAULTS);

        // R1: no opcode open after reset, so a data byte is dropped
        send_data(8'h00);
        check("R1 data before any opcode", obs, DEFAULTS);

        for (int v = 0; v < NV; v++) begin
            send_cmd(VEC[v][72:65]);
            for (int b = 0; b < int'(VEC[v][64:62]); b++) begin
                send_data(VEC[v][61 - 8*(3-b) -: 8]);
            end
            check(VTAG[v], obs, VEC[v][29:0]);
        end
        exp = VEC[NV-1][29:0];

        // R8: a fifth mode byte is dropped
        send_cmd(8'hF3);
        send_data(8'h07); send_data(8'h00); send_data(8'h01); send_data(8'h9C);
        send_data(8'h00);
        check("R8 fifth mode byte", obs, exp);

        // R10: a new opcode mid-transfer restarts the index at byte 0
        send_cmd(8'hF3);
        send_data(8'h07);
        send_data(8'h55);
        send_cmd(8'hF3);
        exp = {1'b0, 7'h2A, 1'b0, 3'b111, 10'h155, 8'h9C};
        check("R10 command strobe writes nothing", obs, exp);
        send_data(8'h00);
        exp = {1'b0, 7'h2A, 1'b0, 3'b000, 10'h155, 8'h9C};
        check("R10 index restarted", obs, exp);

        // R10: both strobes in one cycle -> opcode only
        cmd_stb = 1'b1; data_stb = 1'b1; wr_byte = 8'hD0;
        @(negedge clk);
        cmd_stb = 1'b0; data_stb = 1'b0;
        check("R10 simultaneous strobes", obs, exp);
        // R11: value unchanged before the edge, updated after it
        data_stb = 1'b1; wr_byte = 8'h81;
        #1;
        check("R11 before edge", obs, exp);
        @(negedge clk);
        data_stb = 1'b0;
        exp = {1'b1, 7'h01, 1'b0, 3'b000, 10'h155, 8'h9C};
        check("R11 after edge R2", obs, exp);

        // R1: reset in the middle of operation restores defaults
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset", obs, DEFAULTS);
        send_data(8'hFF);
        check("R1 opcode cleared by reset", obs, DEFAULTS);

        done = 1'b1;
        summary();
    end

endmodule